// File: doc/BRIEF.md
# Shared Data Port Bus Requester

This block is the requesting side of a handshake that shares a 16-bit operand data port among several bus masters. When the core needs an operand read or write, it presents a command with a one-cycle start pulse. The block raises a bus request and watches the arbiter's grant and the bus-busy line. It samples both of them on the falling clock edge. Once a grant is seen and no other master still holds the bus, the block claims ownership with a grant-acknowledge. It withdraws its request in the same cycle and opens the transfer.

While it owns the bus, the block drives the address, the direction, a memory-versus-I/O select, the strobe and, for writes only, the write data. The cycle stays open for as long as the slave withholds its transfer acknowledge, so slow slaves may insert any number of wait states. At the clock edge that sees the acknowledge, read data is captured, every bus driver is released and the core receives a one-cycle done pulse. One transfer is outstanding at a time. Start pulses that arrive before the done pulse are dropped.

Top module: `opbus_master`

## Requirements
- R1: While reset is high and in the cycle after it, bus request, grant-acknowledge, strobe, write-data enable and done are all low, and the direction output reads 1 (read).
- R2: A start pulse seen by an idle block raises the bus request at that clock edge. With no start pulse, the bus request stays low.
- R3: Grant and busy take effect only through their values at the falling clock edge. A grant that rises after one falling edge and falls before the next one never produces a grant-acknowledge.
- R4: Grant-acknowledge rises only at the rising edge after a falling edge that saw grant = 1 and busy = 0. While busy was sampled high, the block keeps requesting and does not acknowledge.
- R5: At the edge that raises grant-acknowledge, the bus request falls. In the same edge the strobe rises and the latched address, direction (1 = read, 0 = write) and I/O select (1 = I/O space, 0 = memory) appear on the bus.
- R6: Address and data paths are 16 bits wide, and every bit, including bit 15 and bit 0, reaches the bus.
- R7: The strobe stays high, with address, direction and I/O select stable, for every rising edge at which the transfer acknowledge is low. There is no limit on the number of such edges.
- R8: At the rising edge that sees the transfer acknowledge during ownership, strobe, grant-acknowledge and write-data enable fall, done rises for exactly one cycle, and for a read the data input at that edge appears on the read-data output.
- R9: A start pulse that arrives while a transfer is outstanding has no effect. The latched command is not replaced, and no further request follows the done pulse.
- R10: The write-data enable is high only while the block owns the bus for a write, and it carries the latched write data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_start | input | 1 | One-cycle pulse requesting an operand transfer |
| xfer_write | input | 1 | 1 = write, 0 = read (taken with the start pulse) |
| xfer_io | input | 1 | 1 = I/O space, 0 = memory space |
| xfer_addr | input | 16 | Transfer address |
| xfer_wdata | input | 16 | Write data |
| xfer_done | output | 1 | One-cycle pulse when the transfer completes |
| xfer_rdata | output | 16 | Read data captured on completion |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_grant | input | 1 | Grant from the arbiter |
| bus_busy | input | 1 | Another master still holds the bus |
| bus_gack | output | 1 | Grant acknowledge, the block owns the bus |
| bus_addr | output | 16 | Bus address, zero when not owning |
| bus_wdata | output | 16 | Write data driven onto the bus |
| bus_wdata_en | output | 1 | Write-data output enable |
| bus_din | input | 16 | Read data from the slave |
| bus_rnw | output | 1 | Direction, 1 = read, 0 = write |
| bus_io | output | 1 | Space select, 1 = I/O, 0 = memory |
| bus_strobe | output | 1 | Data strobe |
| bus_dtack | input | 1 | Transfer acknowledge from the slave |

## Verification
The request appears at the first rising edge after the start pulse. Grant and busy that are changed just after a rising edge are caught by the following falling edge, and their effect appears at the next rising edge. An acknowledge that is raised just after a rising edge ends the cycle at the next rising edge, and done lasts for that single cycle. The bench drives every input 1 ns after a rising edge and reads the outputs at that same point. Each check is therefore made against the edge that the requirement names. The falling-edge case is tested by driving a grant from just after a falling edge until just after the next rising edge. That window is never sampled.

// File: rtl/opbus_pkg.sv
package opbus_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_WAIT = 2'd1,
    ARB_OWN  = 2'd2
  } arb_state_t;

  typedef struct packed {
    logic load_cmd;
    logic take_bus;
    logic release_bus;
  } arb_ctl_t;
endpackage

// File: rtl/opbus_fall_sampler.sv
module opbus_fall_sampler #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  input  logic [WIDTH-1:0] rst_val,
  output logic [WIDTH-1:0] dout
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(negedge clk) begin
      if (rst) dout[i] <= rst_val[i];
      else     dout[i] <= din[i];
    end
  end
endmodule

// File: rtl/opbus_arb_fsm.sv
module opbus_arb_fsm
  import opbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       grant_fe,
  input  logic       busy_fe,
  input  logic       dtack,
  output arb_ctl_t   ctl,
  output logic       req_q,
  output logic       gack_q,
  output logic       strobe_q,
  output logic       done_q
);
  arb_state_t state_q, state_d;
  logic req_d, gack_d, strobe_d, done_d;

  always_comb begin
    state_d  = state_q;
    req_d    = req_q;
    gack_d   = gack_q;
    strobe_d = strobe_q;
    done_d   = 1'b0;
    ctl      = '0;
    unique case (state_q)
      ARB_IDLE: begin
        if (start) begin
          state_d      = ARB_WAIT;
          req_d        = 1'b1;
          ctl.load_cmd = 1'b1;
        end
      end
      ARB_WAIT: begin
        if (grant_fe && !busy_fe) begin
          state_d      = ARB_OWN;
          req_d        = 1'b0;
          gack_d       = 1'b1;
          strobe_d     = 1'b1;
          ctl.take_bus = 1'b1;
        end
      end
      ARB_OWN: begin
        if (dtack) begin
          state_d         = ARB_IDLE;
          gack_d          = 1'b0;
          strobe_d        = 1'b0;
          done_d          = 1'b1;
          ctl.release_bus = 1'b1;
        end
      end
      default: begin
        state_d  = ARB_IDLE;
        req_d    = 1'b0;
        gack_d   = 1'b0;
        strobe_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ARB_IDLE;
      req_q    <= 1'b0;
      gack_q   <= 1'b0;
      strobe_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      req_q    <= req_d;
      gack_q   <= gack_d;
      strobe_q <= strobe_d;
      done_q   <= done_d;
    end
  end
endmodule

// File: rtl/opbus_datapath.sv
module opbus_datapath
  import opbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  arb_ctl_t      ctl,
  input  logic          in_write,
  input  logic          in_io,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_wdata,
  input  logic [DW-1:0] bus_din,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_wdata_en,
  output logic          bus_rnw,
  output logic          bus_io,
  output logic [DW-1:0] rdata
);
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_wdata;
  logic          cmd_write;
  logic          cmd_io;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_addr  <= '0;
      cmd_wdata <= '0;
      cmd_write <= 1'b0;
      cmd_io    <= 1'b0;
    end else if (ctl.load_cmd) begin
      cmd_addr  <= in_addr;
      cmd_wdata <= in_wdata;
      cmd_write <= in_write;
      cmd_io    <= in_io;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr     <= '0;
      bus_wdata    <= '0;
      bus_wdata_en <= 1'b0;
      bus_rnw      <= 1'b1;
      bus_io       <= 1'b0;
    end else if (ctl.take_bus) begin
      bus_addr     <= cmd_addr;
      bus_wdata    <= cmd_wdata;
      bus_wdata_en <= cmd_write;
      bus_rnw      <= ~cmd_write;
      bus_io       <= cmd_io;
    end else if (ctl.release_bus) begin
      bus_addr     <= '0;
      bus_wdata    <= '0;
      bus_wdata_en <= 1'b0;
      bus_rnw      <= 1'b1;
      bus_io       <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                               rdata <= '0;
    else if (ctl.release_bus && !cmd_write) rdata <= bus_din;
  end
endmodule

// File: rtl/opbus_master.sv
module opbus_master
  import opbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xfer_start,
  input  logic          xfer_write,
  input  logic          xfer_io,
  input  logic [AW-1:0] xfer_addr,
  input  logic [DW-1:0] xfer_wdata,
  output logic          xfer_done,
  output logic [DW-1:0] xfer_rdata,
  output logic          bus_req,
  input  logic          bus_grant,
  input  logic          bus_busy,
  output logic          bus_gack,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_wdata_en,
  input  logic [DW-1:0] bus_din,
  output logic          bus_rnw,
  output logic          bus_io,
  output logic          bus_strobe,
  input  logic          bus_dtack
);
  localparam int NSAMP = 2;

  logic [NSAMP-1:0] samp_q;
  arb_ctl_t         ctl;

  opbus_fall_sampler #(.WIDTH(NSAMP)) u_samp (
    .clk     (clk),
    .rst     (rst),
    .din     ({bus_busy, bus_grant}),
    .rst_val ({1'b1, 1'b0}),
    .dout    (samp_q)
  );

  opbus_arb_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .start    (xfer_start),
    .grant_fe (samp_q[0]),
    .busy_fe  (samp_q[1]),
    .dtack    (bus_dtack),
    .ctl      (ctl),
    .req_q    (bus_req),
    .gack_q   (bus_gack),
    .strobe_q (bus_strobe),
    .done_q   (xfer_done)
  );

  opbus_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk          (clk),
    .rst          (rst),
    .ctl          (ctl),
    .in_write     (xfer_write),
    .in_io        (xfer_io),
    .in_addr      (xfer_addr),
    .in_wdata     (xfer_wdata),
    .bus_din      (bus_din),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_wdata_en (bus_wdata_en),
    .bus_rnw      (bus_rnw),
    .bus_io       (bus_io),
    .rdata        (xfer_rdata)
  );
endmodule

// File: rtl/opbus_master_chk.sv
module opbus_master_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_req,
  input logic          bus_gack,
  input logic          bus_strobe,
  input logic          bus_dtack,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rnw,
  input logic          bus_io,
  input logic          bus_wdata_en,
  input logic          xfer_done
);
  AST_GACK_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_gack) |-> $past(bus_req)); // R4

  AST_REQ_DROPS_ON_OWN: assert property (@(posedge clk) disable iff (rst)
    bus_gack |-> !bus_req); // R5

  AST_STROBE_HELD: assert property (@(posedge clk) disable iff (rst)
    bus_strobe && !bus_dtack |=> bus_strobe); // R7

  AST_CMD_STABLE: assert property (@(posedge clk) disable iff (rst)
    bus_strobe && !bus_dtack |=> $stable(bus_addr) && $stable(bus_rnw) && $stable(bus_io)); // R7

  AST_RELEASE_ON_ACK: assert property (@(posedge clk) disable iff (rst)
    bus_strobe && bus_dtack |=> !bus_strobe && !bus_gack && !bus_wdata_en && xfer_done); // R8

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> !xfer_done); // R8

  AST_WEN_ONLY_WRITE: assert property (@(posedge clk) disable iff (rst)
    bus_wdata_en |-> !bus_rnw && bus_gack); // R10
endmodule

bind opbus_master opbus_master_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_req      (bus_req),
  .bus_gack     (bus_gack),
  .bus_strobe   (bus_strobe),
  .bus_dtack    (bus_dtack),
  .bus_addr     (bus_addr),
  .bus_rnw      (bus_rnw),
  .bus_io       (bus_io),
  .bus_wdata_en (bus_wdata_en),
  .xfer_done    (xfer_done)
);

// File: tb/test_opbus_master.sv
`timescale 1ns/100ps
module test_opbus_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        xfer_start = 1'b0, xfer_write = 1'b0, xfer_io = 1'b0;
  logic [15:0] xfer_addr = '0, xfer_wdata = '0, bus_din = '0;
  logic        bus_grant = 1'b0, bus_busy = 1'b1, bus_dtack = 1'b0;
  logic        xfer_done, bus_req, bus_gack, bus_wdata_en, bus_rnw, bus_io, bus_strobe;
  logic [15:0] xfer_rdata, bus_addr, bus_wdata;

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  opbus_master i_opbus_master (.*);

  typedef struct packed {
    logic        wr;
    logic        io;
    logic [15:0] addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic [3:0]  gdly;
    logic [3:0]  waits;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 16'h1234, 16'h0000, 16'hBEEF, 4'd0, 4'd0},
    '{1'b1, 1'b0, 16'hFFFF, 16'h8001, 16'h0000, 4'd2, 4'd1},
    '{1'b0, 1'b1, 16'h8001, 16'h0000, 16'h7FFE, 4'd1, 4'd5},
    '{1'b1, 1'b1, 16'h0001, 16'hA5A5, 16'h0000, 4'd0, 4'd3},
    '{1'b0, 1'b0, 16'h4000, 16'h0000, 16'hFFFF, 4'd4, 4'd12},
    '{1'b1, 1'b0, 16'h00F0, 16'hFFFF, 16'h0000, 4'd3, 4'd0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic run_xfer(input vec_t v);
    xfer_write = v.wr; xfer_io = v.io; xfer_addr = v.addr; xfer_wdata = v.wdata;
    xfer_start = 1'b1;
    tick();
    chk(bus_req == 1'b1, "R2 request raised", bus_req, 1);
    chk(bus_gack == 1'b0, "R4 no gack yet", bus_gack, 0);
    xfer_start = 1'b0; xfer_addr = ~v.addr;
    bus_grant = 1'b1; bus_busy = 1'b1;
    for (int g = 0; g < v.gdly; g++) begin
      tick();
      chk(bus_req && !bus_gack, "R4 busy holds off", {bus_req, bus_gack}, 2'b10);
    end
    bus_busy = 1'b0;
    tick();
    chk(bus_gack == 1'b1, "R4 gack after grant", bus_gack, 1);
    chk(bus_req == 1'b0, "R5 request withdrawn", bus_req, 0);
    chk(bus_strobe == 1'b1, "R5 strobe", bus_strobe, 1);
    chk(bus_addr == v.addr, "R5 R6 address", bus_addr, v.addr);
    chk({bus_rnw, bus_io} == {~v.wr, v.io}, "R5 dir io", {bus_rnw, bus_io}, {~v.wr, v.io});
    chk(bus_wdata_en == v.wr, "R10 wdata enable", bus_wdata_en, v.wr);
    if (v.wr) chk(bus_wdata == v.wdata, "R10 R6 write data", bus_wdata, v.wdata);
    for (int w = 0; w < v.waits; w++) begin
      tick();
      chk(bus_strobe && bus_addr == v.addr && bus_rnw == ~v.wr, "R7 wait state",
          {bus_strobe, bus_addr}, {1'b1, v.addr});
    end
    bus_dtack = 1'b1; bus_din = v.rdata;
    tick();
    chk({bus_strobe, bus_gack, bus_wdata_en} == 3'b000, "R8 release",
        {bus_strobe, bus_gack, bus_wdata_en}, 0);
    chk(xfer_done == 1'b1, "R8 done", xfer_done, 1);
    if (!v.wr) chk(xfer_rdata == v.rdata, "R8 R6 read data", xfer_rdata, v.rdata);
    bus_dtack = 1'b0; bus_grant = 1'b0; bus_busy = 1'b1; bus_din = 16'h0;
    tick();
    chk(xfer_done == 1'b0, "R8 done one cycle", xfer_done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    chk({bus_req, bus_gack, bus_strobe, bus_wdata_en, xfer_done, bus_rnw} == 6'b000001,
        "R1 during reset", {bus_req, bus_gack, bus_strobe, bus_wdata_en, xfer_done, bus_rnw}, 1);
    rst = 1'b0;
    tick();
    chk({bus_req, bus_gack, bus_strobe, bus_wdata_en, xfer_done, bus_rnw} == 6'b000001,
        "R1 after reset", {bus_req, bus_gack, bus_strobe, bus_wdata_en, xfer_done, bus_rnw}, 1);

    // R2: no start pulse, no request even with grant offered
    bus_grant = 1'b1; bus_busy = 1'b0;
    repeat (3) tick();
    chk(bus_req == 1'b0 && bus_gack == 1'b0, "R2 idle no request", {bus_req, bus_gack}, 0);
    bus_grant = 1'b0; bus_busy = 1'b1;

    for (int i = 0; i < NV; i++) run_xfer(VECS[i]);

    // R3: grant present only between falling edges is never taken
    xfer_write = 1'b0; xfer_io = 1'b0; xfer_addr = 16'h0C0C; xfer_start = 1'b1;
    tick();
    xfer_start = 1'b0; bus_busy = 1'b0;
    @(negedge clk); #0.5;
    bus_grant = 1'b1;
    tick();
    chk(bus_gack == 1'b0, "R3 grant after falling edge", bus_gack, 0);
    bus_grant = 1'b0;
    tick();
    chk(bus_gack == 1'b0 && bus_req == 1'b1, "R3 grant pulse ignored", {bus_req, bus_gack}, 2'b10);
    // R9: new start while waiting does not replace the command
    xfer_addr = 16'h5555; xfer_write = 1'b1; xfer_start = 1'b1;
    tick();
    xfer_start = 1'b0;
    bus_grant = 1'b1;
    tick();
    chk(bus_gack && bus_addr == 16'h0C0C && bus_rnw, "R9 command kept",
        {bus_rnw, bus_addr}, {1'b1, 16'h0C0C});
    // R9: start while owning
    xfer_start = 1'b1;
    tick();
    xfer_start = 1'b0; bus_dtack = 1'b1; bus_din = 16'h3C3C;
    tick();
    chk(xfer_done && xfer_rdata == 16'h3C3C, "R8 read after glitch", xfer_rdata, 16'h3C3C);
    bus_dtack = 1'b0; bus_grant = 1'b0; bus_busy = 1'b1;
    repeat (3) begin
      tick();
      chk(bus_req == 1'b0, "R9 no extra request", bus_req, 0);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule